// File: doc/BRIEF.md
# Data-Space Target Decoder for an 8051-Style Core

This block takes one data-memory access per cycle from an 8051-style core and steers it to exactly one physical target: the lower on-chip RAM, the upper on-chip RAM, the special function register space, the on-chip expanded RAM (XRAM), or the off-chip external bus. The choice depends on the address, on how the core is addressing memory (direct, indirect or external-move), and on two control inputs. One control input disables the on-chip XRAM. The other sets how much of the XRAM is visible.

The lower half of the 8-bit internal space is shared by direct and indirect accesses. The upper half is split by addressing mode alone. Direct accesses reach the SFRs and indirect accesses reach a separate upper RAM, even at the same address. External-move accesses reach the on-chip XRAM only if it is enabled and the address falls inside the visible window at the bottom of external data space. All other external-move accesses leave the chip. Simple storage models for the four on-chip targets are included. Read data comes back one cycle after the strobe, through a multiplexer driven by the registered target.

Top module: `data_space_decoder`

## Requirements
- R1: A direct (`acc_type_i`=00) or indirect (`acc_type_i`=01) access with address bit 7 clear asserts `lo_sel_o` and stores to or reads from the lower RAM at index `addr_i[6:0]`.
- R2: A direct access with address bit 7 set asserts `sfr_sel_o` and uses SFR entry `addr_i[6:0]`.
- R3: An indirect access with address bit 7 set asserts `hi_sel_o` and uses upper RAM entry `addr_i[6:0]`. This storage is separate from the SFRs, so an indirect write to A0h leaves the SFR at A0h unchanged.
- R4: An external-move access (`acc_type_i`=10) with `xram_off_i`=0 and `addr_i[15:8]` not above `xram_size_i` asserts `xram_sel_o` and uses XRAM entry `addr_i[9:0]`. The size codes 00, 01, 10 and 11 expose 256, 512, 768 and 1024 bytes.
- R5: An external-move access above the visible XRAM window asserts `ext_sel_o`.
- R6: When `xram_off_i`=1, every external-move access asserts `ext_sel_o`, whatever its address.
- R7: When `rd_i` or `wr_i` is high and the access type is not the reserved code 11, exactly one select is high. When neither strobe is high, or the type is 11, no select is high.
- R8: A read of a valid type raises `rvalid_o` on the next cycle, with the read data on `rdata_o`. An off-chip read returns 00h. Both outputs are 0 after reset.
- R9: A read returns the last byte written to the same target and index. Writes to one target never change another.
- R10: Direct and indirect accesses ignore `addr_i[15:8]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Access address |
| acc_type_i | input | 2 | 00 direct, 01 indirect, 10 external-move, 11 reserved |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| xram_off_i | input | 1 | 1 routes all external-move accesses off-chip |
| xram_size_i | input | 2 | Visible XRAM size code |
| lo_sel_o | output | 1 | Lower RAM select |
| hi_sel_o | output | 1 | Upper RAM select |
| sfr_sel_o | output | 1 | SFR space select |
| xram_sel_o | output | 1 | On-chip XRAM select |
| ext_sel_o | output | 1 | Off-chip external bus select |
| rdata_o | output | 8 | Read data, one cycle after the strobe |
| rvalid_o | output | 1 | Read data valid |

## Verification
On every cycle the assertions check the routing: the address-bit-7 split by mode, the XRAM window limit, the forced off-chip path, exactly one select per valid access, and the one-cycle read-valid timing. Only the bench scenarios can show that the storage behind each select is really separate, and that read data matches what was written. This includes the check that an indirect write at A0h leaves the SFR at A0h intact. The bench also walks the window edge for every size code.

// File: rtl/dsd_pkg.sv
package dsd_pkg;
  typedef enum logic [1:0] {
    ACC_DIR = 2'b00,
    ACC_IND = 2'b01,
    ACC_EXT = 2'b10,
    ACC_RSV = 2'b11
  } acc_e;

  typedef struct packed {
    logic ext;
    logic xram;
    logic sfr;
    logic hi;
    logic lo;
  } tgt_sel_t;
endpackage

// File: rtl/dsd_target_dec.sv
module dsd_target_dec
  import dsd_pkg::*;
#(
  parameter int AW    = 16,
  parameter int BLK_W = 8,
  parameter int SZ_W  = 2
) (
  input  logic [AW-1:0]   addr_i,
  input  logic [1:0]      acc_type_i,
  input  logic            strobe_i,
  input  logic            xram_off_i,
  input  logic [SZ_W-1:0] xram_size_i,
  output tgt_sel_t        sel_o
);
  localparam int BW = AW - BLK_W;

  logic [BW-1:0] blk;
  logic          in_window;

  assign blk       = addr_i[AW-1:BLK_W];
  assign in_window = (blk <= BW'(xram_size_i));

  always_comb begin
    sel_o = '0;
    if (strobe_i) begin
      case (acc_type_i)
        ACC_DIR: if (addr_i[7]) sel_o.sfr = 1'b1; else sel_o.lo = 1'b1;
        ACC_IND: if (addr_i[7]) sel_o.hi  = 1'b1; else sel_o.lo = 1'b1;
        ACC_EXT: if (!xram_off_i && in_window) sel_o.xram = 1'b1;
                 else sel_o.ext = 1'b1;
        default: sel_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/dsd_byte_ram.sv
module dsd_byte_ram #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [IW-1:0] idx_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[idx_i] <= wdata_i;
    if (re_i) rdata_o <= mem[idx_i];
  end
endmodule

// File: rtl/dsd_read_mux.sv
module dsd_read_mux
  import dsd_pkg::*;
#(
  parameter int DW = 8
) (
  input  tgt_sel_t      sel_q_i,
  input  logic [DW-1:0] lo_i,
  input  logic [DW-1:0] hi_i,
  input  logic [DW-1:0] sfr_i,
  input  logic [DW-1:0] xram_i,
  output logic [DW-1:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (sel_q_i.lo)   rdata_o = lo_i;
    if (sel_q_i.hi)   rdata_o = hi_i;
    if (sel_q_i.sfr)  rdata_o = sfr_i;
    if (sel_q_i.xram) rdata_o = xram_i;
  end
endmodule

// File: rtl/data_space_decoder.sv
module data_space_decoder
  import dsd_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 8,
  parameter int BLK_W = 8,
  parameter int SZ_W  = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   addr_i,
  input  logic [1:0]      acc_type_i,
  input  logic            rd_i,
  input  logic            wr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            xram_off_i,
  input  logic [SZ_W-1:0] xram_size_i,
  output logic            lo_sel_o,
  output logic            hi_sel_o,
  output logic            sfr_sel_o,
  output logic            xram_sel_o,
  output logic            ext_sel_o,
  output logic [DW-1:0]   rdata_o,
  output logic            rvalid_o
);
  localparam int HALF_D  = 128;
  localparam int HALF_W  = $clog2(HALF_D);
  localparam int XRAM_D  = (1 << SZ_W) << BLK_W;
  localparam int XRAM_W  = $clog2(XRAM_D);

  tgt_sel_t      sel, sel_q;
  logic          strobe;
  logic [DW-1:0] lo_q, hi_q, sfr_q, xram_q;

  assign strobe = rd_i | wr_i;

  dsd_target_dec #(.AW(AW), .BLK_W(BLK_W), .SZ_W(SZ_W)) u_dec (
    .addr_i      (addr_i),
    .acc_type_i  (acc_type_i),
    .strobe_i    (strobe),
    .xram_off_i  (xram_off_i),
    .xram_size_i (xram_size_i),
    .sel_o       (sel)
  );

  dsd_byte_ram #(.DEPTH(HALF_D), .DW(DW)) u_lo (
    .clk_i, .we_i(sel.lo & wr_i), .re_i(sel.lo & rd_i),
    .idx_i(addr_i[HALF_W-1:0]), .wdata_i, .rdata_o(lo_q)
  );
  dsd_byte_ram #(.DEPTH(HALF_D), .DW(DW)) u_hi (
    .clk_i, .we_i(sel.hi & wr_i), .re_i(sel.hi & rd_i),
    .idx_i(addr_i[HALF_W-1:0]), .wdata_i, .rdata_o(hi_q)
  );
  dsd_byte_ram #(.DEPTH(HALF_D), .DW(DW)) u_sfr (
    .clk_i, .we_i(sel.sfr & wr_i), .re_i(sel.sfr & rd_i),
    .idx_i(addr_i[HALF_W-1:0]), .wdata_i, .rdata_o(sfr_q)
  );
  dsd_byte_ram #(.DEPTH(XRAM_D), .DW(DW)) u_xram (
    .clk_i, .we_i(sel.xram & wr_i), .re_i(sel.xram & rd_i),
    .idx_i(addr_i[XRAM_W-1:0]), .wdata_i, .rdata_o(xram_q)
  );

  // registered target of the last read; held between reads
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q    <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_i & (|sel);
      if (rd_i) sel_q <= sel;
    end
  end

  dsd_read_mux #(.DW(DW)) u_mux (
    .sel_q_i (sel_q),
    .lo_i    (lo_q),
    .hi_i    (hi_q),
    .sfr_i   (sfr_q),
    .xram_i  (xram_q),
    .rdata_o (rdata_o)
  );

  assign lo_sel_o   = sel.lo;
  assign hi_sel_o   = sel.hi;
  assign sfr_sel_o  = sel.sfr;
  assign xram_sel_o = sel.xram;
  assign ext_sel_o  = sel.ext;
endmodule

// File: rtl/dsd_chk.sv
module dsd_chk #(
  parameter int AW    = 16,
  parameter int BLK_W = 8,
  parameter int SZ_W  = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [AW-1:0]   addr_i,
  input logic [1:0]      acc_type_i,
  input logic            rd_i,
  input logic            wr_i,
  input logic            xram_off_i,
  input logic [SZ_W-1:0] xram_size_i,
  input logic            lo_sel_o,
  input logic            hi_sel_o,
  input logic            sfr_sel_o,
  input logic            xram_sel_o,
  input logic            ext_sel_o,
  input logic            rvalid_o
);
  localparam int BW = AW - BLK_W;

  logic       stb;
  logic [4:0] sels;
  logic       mode_int;
  logic       above;

  assign stb      = rd_i | wr_i;
  assign sels     = {ext_sel_o, xram_sel_o, sfr_sel_o, hi_sel_o, lo_sel_o};
  assign mode_int = (acc_type_i == 2'b00) || (acc_type_i == 2'b01);
  assign above    = addr_i[AW-1:BLK_W] > BW'(xram_size_i);

  // R1
  lo_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb && mode_int && !addr_i[7] |-> lo_sel_o);
  // R2
  sfr_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb && acc_type_i == 2'b00 && addr_i[7] |-> sfr_sel_o);
  // R3
  hi_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb && acc_type_i == 2'b01 && addr_i[7] |-> hi_sel_o);
  // R4
  xram_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb && acc_type_i == 2'b10 && !xram_off_i && !above |-> xram_sel_o);
  // R5
  ext_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb && acc_type_i == 2'b10 && above |-> ext_sel_o);
  // R6
  ext_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb && acc_type_i == 2'b10 && xram_off_i |-> ext_sel_o);
  // R7
  one_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb && acc_type_i != 2'b11 |-> $countones(sels) == 1);
  // R7
  idle_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb || acc_type_i == 2'b11 |-> sels == 5'b0);
  // R8
  rvalid_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && acc_type_i != 2'b11 |=> rvalid_o);
  // R8
  rvalid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> !rvalid_o);
endmodule

bind data_space_decoder dsd_chk #(.AW(AW), .BLK_W(BLK_W), .SZ_W(SZ_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .acc_type_i  (acc_type_i),
  .rd_i        (rd_i),
  .wr_i        (wr_i),
  .xram_off_i  (xram_off_i),
  .xram_size_i (xram_size_i),
  .lo_sel_o    (lo_sel_o),
  .hi_sel_o    (hi_sel_o),
  .sfr_sel_o   (sfr_sel_o),
  .xram_sel_o  (xram_sel_o),
  .ext_sel_o   (ext_sel_o),
  .rvalid_o    (rvalid_o)
);

// File: tb/data_space_decoder_test.sv
module data_space_decoder_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [1:0]  acc = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [7:0]  wdata = '0;
  logic        xoff = 1'b0;
  logic [1:0]  xsz = '0;
  logic        lo_s, hi_s, sfr_s, xr_s, ext_s, rvalid;
  logic [7:0]  rdata;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_lo [128];
  logic [7:0] m_hi [128];
  logic [7:0] m_sfr[128];
  logic [7:0] m_xr [1024];

  always #(CLK_PERIOD/2) clk = ~clk;

  data_space_decoder uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .acc_type_i(acc),
    .rd_i(rd), .wr_i(wr), .wdata_i(wdata), .xram_off_i(xoff),
    .xram_size_i(xsz), .lo_sel_o(lo_s), .hi_sel_o(hi_s), .sfr_sel_o(sfr_s),
    .xram_sel_o(xr_s), .ext_sel_o(ext_s), .rdata_o(rdata), .rvalid_o(rvalid)
  );

  // expected select vector {ext,xram,sfr,hi,lo}
  function automatic logic [4:0] exp_sel(logic [1:0] t, logic [15:0] a,
                                         logic stb, logic off, logic [1:0] sz);
    if (!stb) return 5'b0;
    case (t)
      2'b00: return a[7] ? 5'b00100 : 5'b00001;
      2'b01: return a[7] ? 5'b00010 : 5'b00001;
      2'b10: return (!off && a[15:8] <= {6'b0, sz}) ? 5'b01000 : 5'b10000;
      default: return 5'b0;
    endcase
  endfunction

  function automatic logic [7:0] model_rd(logic [4:0] s, logic [15:0] a);
    case (s)
      5'b00001: return m_lo[a[6:0]];
      5'b00010: return m_hi[a[6:0]];
      5'b00100: return m_sfr[a[6:0]];
      5'b01000: return m_xr[a[9:0]];
      default:  return 8'h00;
    endcase
  endfunction

  task automatic chk8(string req, logic [7:0] act, logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic access(logic [1:0] t, logic [15:0] a, logic r, logic w,
                        logic [7:0] d, logic off, logic [1:0] sz, string req);
    logic [4:0] es;
    logic [7:0] ed;
    @(negedge clk);
    acc = t; addr = a; rd = r; wr = w; wdata = d; xoff = off; xsz = sz;
    #1;
    es = exp_sel(t, a, r | w, off, sz);
    chk8(req, {3'b0, ext_s, xr_s, sfr_s, hi_s, lo_s}, {3'b0, es});
    ed = model_rd(es, a);
    if (w) begin
      case (es)
        5'b00001: m_lo[a[6:0]] = d;
        5'b00010: m_hi[a[6:0]] = d;
        5'b00100: m_sfr[a[6:0]] = d;
        5'b01000: m_xr[a[9:0]] = d;
        default: ;
      endcase
    end
    @(negedge clk);
    rd = 1'b0; wr = 1'b0;
    #1;
    if (r) begin
      chk8({req, " rvalid"}, {7'b0, rvalid}, {7'b0, es != 5'b0});
      if (es != 5'b0) chk8({req, " rdata"}, rdata, ed);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    #(CLK_PERIOD * 2);
    #1;
    // R8 reset state
    chk8("R8 reset sel", {3'b0, ext_s, xr_s, sfr_s, hi_s, lo_s}, 8'h00);
    chk8("R8 reset rvalid", {7'b0, rvalid}, 8'h00);
    chk8("R8 reset rdata", rdata, 8'h00);
    rst_n = 1'b1;

    // fill every on-chip location; R1 R2 R3 R4
    for (int i = 0; i < 128; i++) access(2'b00, 16'(i), 0, 1, 8'(i*3+1), 0, 3, "R1 fill");
    for (int i = 128; i < 256; i++) access(2'b01, 16'(i), 0, 1, 8'(i*5+2), 0, 3, "R3 fill");
    for (int i = 128; i < 256; i++) access(2'b00, 16'(i), 0, 1, 8'(i*7+3), 0, 3, "R2 fill");
    for (int i = 0; i < 1024; i++) access(2'b10, 16'(i), 0, 1, 8'(i*11+5), 0, 3, "R4 fill");

    // R3 indirect write at A0h keeps SFR A0h
    access(2'b01, 16'h00A0, 0, 1, 8'h5A, 0, 0, "R3 ind wr A0");
    access(2'b00, 16'h00A0, 1, 0, 8'h00, 0, 0, "R3 sfr A0 untouched");
    chk8("R3 sfr A0 value", rdata, 8'(8'hA0*7+3));
    access(2'b01, 16'h00A0, 1, 0, 8'h00, 0, 0, "R3 ind rd A0");
    chk8("R3 upper A0 value", rdata, 8'h5A);

    // R4 R5 window edges for each size code
    for (int s = 0; s < 4; s++) begin
      access(2'b10, 16'((s+1)*256 - 1), 1, 0, 8'h00, 0, 2'(s), "R4 top of window");
      access(2'b10, 16'((s+1)*256), 1, 0, 8'h00, 0, 2'(s), "R5 past window");
      chk8("R8 ext read zero", rdata, 8'h00);
    end
    access(2'b10, 16'hF123, 0, 1, 8'h77, 0, 3, "R5 far ext");

    // R6 disabled XRAM
    access(2'b10, 16'h0000, 1, 0, 8'h00, 1, 3, "R6 off addr 0");
    access(2'b10, 16'h0000, 0, 1, 8'hEE, 1, 3, "R6 off write");
    access(2'b10, 16'h0000, 1, 0, 8'h00, 0, 3, "R6 xram kept");
    chk8("R6 xram 0 unchanged", rdata, 8'h05);

    // R10 upper address bits ignored
    access(2'b00, 16'h1234, 1, 0, 8'h00, 0, 0, "R10 dir high bits");
    access(2'b01, 16'hFFC5, 0, 1, 8'h3C, 0, 0, "R10 ind high bits");
    access(2'b01, 16'h00C5, 1, 0, 8'h00, 0, 0, "R10 ind readback");

    // R7 no strobe / reserved type
    access(2'b11, 16'h0010, 1, 0, 8'h00, 0, 0, "R7 reserved rd");
    access(2'b11, 16'h0010, 0, 1, 8'h99, 0, 0, "R7 reserved wr");
    access(2'b00, 16'h0010, 1, 0, 8'h00, 0, 0, "R7 reserved no effect");
    access(2'b00, 16'h0090, 0, 0, 8'h00, 0, 0, "R7 idle");

    // R9 random mix
    for (int n = 0; n < 3000; n++) begin
      logic [1:0]  t  = 2'($urandom_range(0, 3));
      logic [15:0] a  = ($urandom_range(0, 7) == 0) ? 16'($urandom) : 16'($urandom_range(0, 1279));
      logic        w  = 1'($urandom);
      logic [1:0]  sz = 2'($urandom);
      logic        of = ($urandom_range(0, 5) == 0);
      access(t, a, !w, w, 8'($urandom), of, sz, "R9 random");
    end

    finish_run();
  end
endmodule